// File: doc/BRIEF.md
# Three-Slot Bundle Dispatcher

The dispatcher sits between an instruction buffer and a fixed set of functional-unit ports: one memory port, one integer port, one floating-point port and three branch ports. The buffer presents up to two 128-bit bundles per cycle, the head bundle and the one behind it. Each bundle holds a 5-bit template and three 41-bit instruction slots. The template names the unit class of every slot and marks the group boundaries (stops). The dispatcher looks up the template, hands each slot to a free port of the right class, and tells the buffer how many bundles it has used up in that cycle.

Slots of the head bundle go out in slot order. A slot that finds no free port waits for the next cycle, and so does every later slot. A stop also holds the remaining slots back. The bundle behind the head goes out in the same cycle only as a whole. The head bundle must have finished without meeting a stop, and every slot of the second bundle must find a port. A small internal register records which head slots have already gone out, so that a partly dispatched bundle resumes where it left off. All outputs are combinational from that register and the two bundle inputs.

Top module: `bd_dispatch`

## Requirements
- R1: While `rst` is high, every port valid, `int_long`, `illegal` and `consume` are 0. A reset also clears the record of already dispatched head slots, so the head bundle restarts from slot 0 once `rst` falls.
- R2: The template is bits [4:0] of a bundle. Slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. A port's instruction bus carries the chosen slot's bits unaltered, and it is zero when the port's valid is low.
- R3: Templates are decoded from code[4:1], and code[0] adds a stop after slot 2. The base values are: 0=M I I, 1=M A I with a stop after slot 1, 2=M L X, 3=A A F, 4=M M I, 6=M F I, 8=M I B, 9=M B B, 10=A I B, 11=B B B, 12=M M B, 14=M F B. The remaining bases (5, 7, 13, 15) are illegal.
- R4: An M slot goes to the memory port, an I slot to the integer port and an F slot to the floating-point port. B slots fill the branch ports lowest index first, so branch valids are always contiguous from index 0. An A slot takes the memory port if it is still free and the integer port otherwise.
- R5: An L slot (slot 1) takes the integer port together with its X partner (slot 2). `int_long` is then high, and `int_ext` carries slot 2, while `int_instr` carries slot 1.
- R6: Head slots dispatch in slot order. When a slot finds its port class taken, that slot and all later head slots wait for a later cycle.
- R7: After a dispatched slot that carries a stop, no later slot of the head bundle dispatches in that cycle. The held slots dispatch in the next cycle.
- R8: The second bundle dispatches in the same cycle only when all of these hold: the head bundle completes in this cycle; no slot of the head dispatched in this cycle carries a stop; the second bundle is valid and legal and has no stop after slot 0 or slot 1; and all of its slots fit the ports the head left free. If any condition fails, none of its slots dispatch.
- R9: `consume` equals the number of bundles used up in the cycle: 0, 1 (head only) or 2 (head and second). A bundle left behind becomes the head in the next cycle.
- R10: A head bundle with an illegal template raises `illegal` and dispatches nothing, not even a second bundle. `consume` is 1, which discards the bundle.
- R11: When `b0_valid` is low, nothing dispatches, `consume` is 0 and the head progress record is kept, whatever the second bundle input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b0_valid | input | 1 | Head bundle present |
| b0_data | input | 128 | Head bundle |
| b1_valid | input | 1 | Second bundle present |
| b1_data | input | 128 | Second bundle |
| consume | output | 2 | Bundles used up this cycle |
| illegal | output | 1 | Head template is not a known code |
| mem_v | output | 1 | Memory port valid |
| mem_instr | output | 41 | Memory port instruction |
| int_v | output | 1 | Integer port valid |
| int_instr | output | 41 | Integer port instruction |
| int_long | output | 1 | Integer port carries a two-slot long form |
| int_ext | output | 41 | Second half of a long form |
| fp_v | output | 1 | Floating-point port valid |
| fp_instr | output | 41 | Floating-point port instruction |
| br_v | output | 3 | Branch port valids, index 0 first |
| br_instr | output | 123 | Branch port instructions, port k at bits [41k+40:41k] |

## Verification
The bench targets a head bundle that needs a port twice, such as M M I. A design that skipped the blocked slot and let a later one pass would dispatch out of order, and one that lost its progress record would send the first M twice. Stops are exercised in the middle of a bundle, at the end of the head bundle and inside the second bundle; a design that ignored any of them would pair bundles that must stay apart and report a consume count of 2. The A slot's choice between the memory and integer ports is covered, as are a long form placed as head and as second bundle, and an illegal second bundle behind a legal head. Resets and idle cycles that arrive in the middle of a bundle are also covered, so a design that kept stale progress after reset, or advanced during an idle cycle, would re-dispatch slots or skip them.

// File: rtl/bd_pkg.sv
package bd_pkg;

    localparam int SLOT_W   = 41;
    localparam int TMPL_W   = 5;
    localparam int NSLOT    = 3;
    localparam int BUNDLE_W = TMPL_W + NSLOT * SLOT_W;
    localparam int NBR      = 3;
    localparam int NBUNDLE  = 2;
    localparam int SEL_W    = $clog2(NBUNDLE * NSLOT);
    localparam int NSRC     = 1 << SEL_W;

    typedef enum logic [2:0] {
        U_M = 3'd0,
        U_I = 3'd1,
        U_A = 3'd2,
        U_F = 3'd3,
        U_B = 3'd4,
        U_L = 3'd5,
        U_X = 3'd6
    } unit_e;

    typedef struct packed {
        logic             legal;
        unit_e            t2;
        unit_e            t1;
        unit_e            t0;
        logic [NSLOT-1:0] stop;
    } tmpl_t;

    typedef struct packed {
        logic                      mem_v;
        logic [SEL_W-1:0]          mem_sel;
        logic                      int_v;
        logic [SEL_W-1:0]          int_sel;
        logic                      int_long;
        logic                      fp_v;
        logic [SEL_W-1:0]          fp_sel;
        logic [NBR-1:0]            br_v;
        logic [NBR-1:0][SEL_W-1:0] br_sel;
    } grant_t;

    function automatic tmpl_t tmpl_lookup(input logic [TMPL_W-1:0] code);
        tmpl_t r;
        r       = '0;
        r.legal = 1'b1;
        r.stop  = {code[0], {(NSLOT-1){1'b0}}};
        case (code[4:1])
            4'd0:  begin r.t0 = U_M; r.t1 = U_I; r.t2 = U_I; end
            4'd1:  begin r.t0 = U_M; r.t1 = U_A; r.t2 = U_I; r.stop[1] = 1'b1; end
            4'd2:  begin r.t0 = U_M; r.t1 = U_L; r.t2 = U_X; end
            4'd3:  begin r.t0 = U_A; r.t1 = U_A; r.t2 = U_F; end
            4'd4:  begin r.t0 = U_M; r.t1 = U_M; r.t2 = U_I; end
            4'd6:  begin r.t0 = U_M; r.t1 = U_F; r.t2 = U_I; end
            4'd8:  begin r.t0 = U_M; r.t1 = U_I; r.t2 = U_B; end
            4'd9:  begin r.t0 = U_M; r.t1 = U_B; r.t2 = U_B; end
            4'd10: begin r.t0 = U_A; r.t1 = U_I; r.t2 = U_B; end
            4'd11: begin r.t0 = U_B; r.t1 = U_B; r.t2 = U_B; end
            4'd12: begin r.t0 = U_M; r.t1 = U_M; r.t2 = U_B; end
            4'd14: begin r.t0 = U_M; r.t1 = U_F; r.t2 = U_B; end
            default: begin
                r.legal = 1'b0;
                r.stop  = '0;
            end
        endcase
        return r;
    endfunction

    function automatic unit_e slot_ty(input tmpl_t t, input int s);
        unit_e u;
        case (s)
            0:       u = t.t0;
            1:       u = t.t1;
            default: u = t.t2;
        endcase
        return u;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [BUNDLE_W-1:0] b, input int s);
        return b[TMPL_W + s * SLOT_W +: SLOT_W];
    endfunction

    // Try to grant one slot a port of its class; returns 1 on success.
    function automatic logic claim(input unit_e u, input logic [SEL_W-1:0] idx, inout grant_t g);
        logic ok;
        ok = 1'b0;
        case (u)
            U_M: if (!g.mem_v) begin g.mem_v = 1'b1; g.mem_sel = idx; ok = 1'b1; end
            U_I: if (!g.int_v) begin g.int_v = 1'b1; g.int_sel = idx; ok = 1'b1; end
            U_L: if (!g.int_v) begin
                g.int_v    = 1'b1;
                g.int_sel  = idx;
                g.int_long = 1'b1;
                ok         = 1'b1;
            end
            U_A: begin
                if (!g.mem_v) begin
                    g.mem_v = 1'b1; g.mem_sel = idx; ok = 1'b1;
                end else if (!g.int_v) begin
                    g.int_v = 1'b1; g.int_sel = idx; ok = 1'b1;
                end
            end
            U_F: if (!g.fp_v) begin g.fp_v = 1'b1; g.fp_sel = idx; ok = 1'b1; end
            U_B: begin
                for (int k = 0; k < NBR; k++) begin
                    if (!ok && !g.br_v[k]) begin
                        g.br_v[k]   = 1'b1;
                        g.br_sel[k] = idx;
                        ok          = 1'b1;
                    end
                end
            end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bd_tmpl_dec.sv
module bd_tmpl_dec
    import bd_pkg::*;
(
    input  logic [TMPL_W-1:0] code,
    output tmpl_t             tmpl
);
    always_comb begin
        tmpl = tmpl_lookup(code);
    end
endmodule

// File: rtl/bd_port_alloc.sv
module bd_port_alloc
    import bd_pkg::*;
(
    input  logic             v0,
    input  tmpl_t            t0,
    input  logic [NSLOT-1:0] done,
    input  logic             v1,
    input  tmpl_t            t1,
    output grant_t           grant,
    output logic [NSLOT-1:0] sent0,
    output logic             b0_finish,
    output logic             pair,
    output logic             bad0
);
    localparam logic [NSLOT-1:0] MID_STOPS = {1'b0, {(NSLOT-1){1'b1}}};

    grant_t           g0, g1;
    logic             go, ok, fit1, stopped;
    logic [NSLOT-1:0] s0m;

    always_comb begin
        g0   = '0;
        s0m  = '0;
        go   = 1'b1;
        ok   = 1'b0;
        bad0 = v0 && !t0.legal;
        if (v0 && t0.legal) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (go && !done[s] && slot_ty(t0, s) != U_X) begin
                    ok = claim(slot_ty(t0, s), SEL_W'(s), g0);
                    if (ok) begin
                        s0m[s] = 1'b1;
                        if (t0.stop[s]) go = 1'b0;
                    end else begin
                        go = 1'b0;
                    end
                end
            end
            // the second half of a long form leaves with its first half
            for (int s = 1; s < NSLOT; s++) begin
                if (slot_ty(t0, s) == U_X && s0m[s-1]) s0m[s] = 1'b1;
            end
        end
        stopped   = |(s0m & t0.stop);
        b0_finish = v0 && t0.legal && (&(done | s0m));

        g1   = g0;
        fit1 = 1'b1;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_ty(t1, s) != U_X) begin
                if (!claim(slot_ty(t1, s), SEL_W'(NSLOT + s), g1)) fit1 = 1'b0;
            end
        end
        pair  = b0_finish && !stopped && v1 && t1.legal &&
                ((t1.stop & MID_STOPS) == '0) && fit1;
        grant = pair ? g1 : g0;
        sent0 = s0m;
    end
endmodule

// File: rtl/bd_progress.sv
module bd_progress
    import bd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             finish,
    input  logic [NSLOT-1:0] sent,
    output logic [NSLOT-1:0] done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= '0;
        end else if (advance) begin
            done <= finish ? '0 : (done | sent);
        end
    end
endmodule

// File: rtl/bd_dispatch.sv
module bd_dispatch
    import bd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  b0_valid,
    input  logic [BUNDLE_W-1:0]   b0_data,
    input  logic                  b1_valid,
    input  logic [BUNDLE_W-1:0]   b1_data,
    output logic [1:0]            consume,
    output logic                  illegal,
    output logic                  mem_v,
    output logic [SLOT_W-1:0]     mem_instr,
    output logic                  int_v,
    output logic [SLOT_W-1:0]     int_instr,
    output logic                  int_long,
    output logic [SLOT_W-1:0]     int_ext,
    output logic                  fp_v,
    output logic [SLOT_W-1:0]     fp_instr,
    output logic [NBR-1:0]        br_v,
    output logic [NBR*SLOT_W-1:0] br_instr
);
    logic [BUNDLE_W-1:0] bdata [NBUNDLE];
    tmpl_t               tm    [NBUNDLE];
    logic [SLOT_W-1:0]   slot_all [NSRC];

    assign bdata[0] = b0_data;
    assign bdata[1] = b1_data;

    generate
        for (genvar b = 0; b < NBUNDLE; b++) begin : g_dec
            bd_tmpl_dec u_dec (
                .code (bdata[b][TMPL_W-1:0]),
                .tmpl (tm[b])
            );
            for (genvar s = 0; s < NSLOT; s++) begin : g_slot
                assign slot_all[b*NSLOT + s] = slot_of(bdata[b], s);
            end
        end
        for (genvar e = NBUNDLE * NSLOT; e < NSRC; e++) begin : g_pad
            assign slot_all[e] = '0;
        end
    endgenerate

    grant_t           grant;
    logic [NSLOT-1:0] sent0, done;
    logic             b0_finish, pair, bad0;

    bd_port_alloc u_alloc (
        .v0        (b0_valid),
        .t0        (tm[0]),
        .done      (done),
        .v1        (b1_valid),
        .t1        (tm[1]),
        .grant     (grant),
        .sent0     (sent0),
        .b0_finish (b0_finish),
        .pair      (pair),
        .bad0      (bad0)
    );

    bd_progress u_prog (
        .clk     (clk),
        .rst     (rst),
        .advance (b0_valid),
        .finish  (b0_finish),
        .sent    (sent0),
        .done    (done)
    );

    logic live;
    assign live = !rst;

    assign consume   = live ? (2'(b0_finish || bad0) + 2'(pair)) : 2'd0;
    assign illegal   = live && bad0;
    assign mem_v     = live && grant.mem_v;
    assign mem_instr = mem_v ? slot_all[grant.mem_sel] : '0;
    assign int_v     = live && grant.int_v;
    assign int_instr = int_v ? slot_all[grant.int_sel] : '0;
    assign int_long  = live && grant.int_long;
    assign int_ext   = int_long ? slot_all[grant.int_sel + SEL_W'(1)] : '0;
    assign fp_v      = live && grant.fp_v;
    assign fp_instr  = fp_v ? slot_all[grant.fp_sel] : '0;

    generate
        for (genvar k = 0; k < NBR; k++) begin : g_br
            assign br_v[k] = live && grant.br_v[k];
            assign br_instr[k*SLOT_W +: SLOT_W] = br_v[k] ? slot_all[grant.br_sel[k]] : '0;
        end
    endgenerate
endmodule

// File: rtl/bd_dispatch_chk.sv
module bd_dispatch_chk #(
    parameter int NBR = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           b0_valid,
    input logic           b1_valid,
    input logic [1:0]     consume,
    input logic           illegal,
    input logic           mem_v,
    input logic           int_v,
    input logic           int_long,
    input logic           fp_v,
    input logic [NBR-1:0] br_v
);
    logic any_v;
    assign any_v = mem_v || int_v || fp_v || (br_v != '0);

    always @(posedge clk) begin
        if (rst) begin
            a_r1_quiet_in_reset: assert (consume == 2'd0 && !illegal && !any_v && !int_long);
        end
    end

    a_r9_consume_range: assert property (@(posedge clk) disable iff (rst)
        consume != 2'd3);

    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!any_v && consume == 2'd1));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !b0_valid |-> (!any_v && consume == 2'd0 && !illegal));

    a_r8_pair_needs_second: assert property (@(posedge clk) disable iff (rst)
        (consume == 2'd2) |-> b1_valid);

    a_r5_long_on_int: assert property (@(posedge clk) disable iff (rst)
        int_long |-> int_v);

    a_r4_branch_fill: assert property (@(posedge clk) disable iff (rst)
        ((br_v + NBR'(1)) & br_v) == '0);
endmodule

bind bd_dispatch bd_dispatch_chk #(.NBR(bd_pkg::NBR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .b0_valid (b0_valid),
    .b1_valid (b1_valid),
    .consume  (consume),
    .illegal  (illegal),
    .mem_v    (mem_v),
    .int_v    (int_v),
    .int_long (int_long),
    .fp_v     (fp_v),
    .br_v     (br_v)
);

// File: tb/bd_dispatch_tb.sv
module bd_dispatch_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         b0_valid = 1'b0, b1_valid = 1'b0;
    logic [127:0] b0_data = '0, b1_data = '0;
    logic [1:0]   consume;
    logic         illegal, mem_v, int_v, int_long, fp_v;
    logic [40:0]  mem_instr, int_instr, int_ext, fp_instr;
    logic [2:0]   br_v;
    logic [122:0] br_instr;

    always #(CLK_PERIOD/2) clk = ~clk;

    bd_dispatch u_dut (
        .clk(clk), .rst(rst),
        .b0_valid(b0_valid), .b0_data(b0_data),
        .b1_valid(b1_valid), .b1_data(b1_data),
        .consume(consume), .illegal(illegal),
        .mem_v(mem_v), .mem_instr(mem_instr),
        .int_v(int_v), .int_instr(int_instr),
        .int_long(int_long), .int_ext(int_ext),
        .fp_v(fp_v), .fp_instr(fp_instr),
        .br_v(br_v), .br_instr(br_instr)
    );

    int tests = 0;
    int fails = 0;

    logic [127:0] q[$];
    int           done_m = 0;
    int           n_done, n_pop;

    bit          x_ill, x_mem_v, x_int_v, x_long, x_fp_v;
    int          x_cons, brn;
    logic [40:0] x_mem_i, x_int_i, x_ext_i, x_fp_i;
    bit   [2:0]  x_br_v;
    logic [40:0] x_br_i [3];

    function automatic logic [40:0] slot(input logic [127:0] d, input int k);
        return d[5 + 41*k +: 41];
    endfunction

    function automatic logic [127:0] mk(input int code, input int tag);
        logic [127:0] d;
        d[4:0] = 5'(code);
        for (int k = 0; k < 3; k++) d[5 + 41*k +: 41] = {8'(tag), 2'(k), 31'(tag * 7919 + k * 13 + 1)};
        return d;
    endfunction

    // unit letters per slot from the template code (R3)
    function automatic string tdec(input logic [4:0] code);
        case (code[4:1])
            0: return "MII";  1: return "MAI";  2: return "MLX";  3: return "AAF";
            4: return "MMI";  6: return "MFI";  8: return "MIB";  9: return "MBB";
            10: return "AIB"; 11: return "BBB"; 12: return "MMB"; 14: return "MFB";
            default: return "";
        endcase
    endfunction

    function automatic bit stop_at(input logic [127:0] d, input int j);
        if (j == 2) return d[0];
        return (j == 1) && (d[4:1] == 4'd1);
    endfunction

    task automatic put(input byte u, input logic [127:0] d, input int s, output bit ok);
        ok = 1'b0;
        if (u == "M" || (u == "A" && !x_mem_v)) begin
            if (!x_mem_v) begin x_mem_v = 1; x_mem_i = slot(d, s); ok = 1; end
        end else if (u == "I" || u == "A" || u == "L") begin
            if (!x_int_v) begin
                x_int_v = 1; x_int_i = slot(d, s); ok = 1;
                if (u == "L") begin x_long = 1; x_ext_i = slot(d, s + 1); end
            end
        end else if (u == "F") begin
            if (!x_fp_v) begin x_fp_v = 1; x_fp_i = slot(d, s); ok = 1; end
        end else if (u == "B") begin
            if (brn < 3) begin x_br_v[brn] = 1; x_br_i[brn] = slot(d, s); brn++; ok = 1; end
        end
    endtask

    task automatic clear_exp();
        x_ill = 0; x_mem_v = 0; x_int_v = 0; x_long = 0; x_fp_v = 0; x_cons = 0; brn = 0;
        x_mem_i = '0; x_int_i = '0; x_ext_i = '0; x_fp_i = '0; x_br_v = '0;
        for (int k = 0; k < 3; k++) x_br_i[k] = '0;
    endtask

    task automatic model(input bit v0, input logic [127:0] d0, input bit v1, input logic [127:0] d1);
        string a, b;
        bit    halted, stp, ok, complete, pr;
        int    sent, nm, ni, na, nf, nb, fm, fi;
        clear_exp();
        n_done = done_m; n_pop = 0;
        if (!v0) return;
        a = tdec(d0[4:0]);
        if (a == "") begin
            x_ill = 1; x_cons = 1; n_pop = 1; n_done = 0;
            return;
        end
        halted = 0; stp = 0; sent = 0;
        for (int s = 0; s < 3; s++) begin
            if (!halted && !done_m[s] && a[s] != "X") begin
                put(a[s], d0, s, ok);
                if (ok) begin
                    sent |= 1 << s;
                    if (a[s] == "L") sent |= 1 << (s + 1);
                    if (stop_at(d0, s)) halted = 1;
                end else halted = 1;
            end
        end
        for (int s = 0; s < 3; s++) if (sent[s] && stop_at(d0, s)) stp = 1;
        complete = ((done_m | sent) & 7) == 7;
        pr = 0;
        b = v1 ? tdec(d1[4:0]) : "";
        if (complete && !stp && b != "" && !stop_at(d1, 0) && !stop_at(d1, 1)) begin
            nm = 0; ni = 0; na = 0; nf = 0; nb = 0;
            for (int s = 0; s < 3; s++) begin
                case (b[s])
                    "M": nm++;
                    "I", "L": ni++;
                    "A": na++;
                    "F": nf++;
                    "B": nb++;
                    default: ;
                endcase
            end
            fm = x_mem_v ? 0 : 1;
            fi = x_int_v ? 0 : 1;
            pr = nm <= fm && ni <= fi && nf <= (x_fp_v ? 0 : 1) && nb <= 3 - brn &&
                 na <= (fm - nm) + (fi - ni);
            if (pr) for (int s = 0; s < 3; s++) if (b[s] != "X") put(b[s], d1, s, ok);
        end
        x_cons = (complete ? 1 : 0) + (pr ? 1 : 0);
        n_pop  = x_cons;
        n_done = complete ? 0 : (done_m | sent);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string ph);
        chk({"R9/", ph}, "consume", 64'(consume), 64'(x_cons));
        chk({"R10/", ph}, "illegal", 64'(illegal), 64'(x_ill));
        chk({"R4/", ph}, "mem_v", 64'(mem_v), 64'(x_mem_v));
        chk({"R2/", ph}, "mem_instr", 64'(mem_instr), 64'(x_mem_i));
        chk({"R4/", ph}, "int_v", 64'(int_v), 64'(x_int_v));
        chk({"R2/", ph}, "int_instr", 64'(int_instr), 64'(x_int_i));
        chk({"R5/", ph}, "int_long", 64'(int_long), 64'(x_long));
        chk({"R5/", ph}, "int_ext", 64'(int_ext), 64'(x_ext_i));
        chk({"R4/", ph}, "fp_v", 64'(fp_v), 64'(x_fp_v));
        chk({"R2/", ph}, "fp_instr", 64'(fp_instr), 64'(x_fp_i));
        chk({"R4/", ph}, "br_v", 64'(br_v), 64'(x_br_v));
        for (int k = 0; k < 3; k++)
            chk({"R2/", ph}, "br_instr", 64'(br_instr[41*k +: 41]), 64'(x_br_i[k]));
    endtask

    // Drain the queue; gap = cycle index driven idle, rst_at = cycle index held in reset
    task automatic run(input string ph, input int gap, input int rst_at);
        int cyc = 0;
        while (q.size() > 0) begin
            @(negedge clk);
            rst      = (cyc == rst_at);
            b0_valid = (cyc != gap);
            b0_data  = q[0];
            b1_valid = (q.size() > 1) || (cyc == gap);
            b1_data  = (q.size() > 1) ? q[1] : mk(22, 99);
            #1;
            if (rst) begin
                clear_exp();
                compare({"R1/", ph});
                done_m = 0;
            end else begin
                model(b0_valid, b0_data, b1_valid, b1_data);
                compare(ph);
                done_m = n_done;
                repeat (n_pop) void'(q.pop_front());
            end
            cyc++;
        end
        @(negedge clk);
        rst = 0; b0_valid = 0; b1_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: quiet while reset is held, even with a valid bundle
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            b0_valid = 1; b0_data = mk(22, 1); b1_valid = 1; b1_data = mk(12, 2);
            #1;
            clear_exp();
            compare("R1");
        end
        @(negedge clk);
        rst = 0; b0_valid = 0; b1_valid = 0;

        // R1: reset in the middle of an M M I bundle restarts it
        q.push_back(mk(8, 3));
        run("R1", -1, 1);

        // R2: field positions and unaltered slot bits
        q.push_back(mk(29, 4)); q.push_back(mk(17, 5)); q.push_back(mk(1, 6));
        run("R2", -1, -1);

        // R3/R4: class routing, A choice, branch fill order
        q.push_back(mk(7, 7)); q.push_back(mk(21, 8)); q.push_back(mk(19, 9));
        q.push_back(mk(23, 10)); q.push_back(mk(25, 11));
        run("R3", -1, -1);

        // R5: long form as head and as second bundle
        q.push_back(mk(5, 12)); q.push_back(mk(4, 13)); q.push_back(mk(22, 14));
        q.push_back(mk(4, 15)); q.push_back(mk(12, 16)); q.push_back(mk(23, 17));
        q.push_back(mk(22, 18)); q.push_back(mk(5, 19));
        run("R5", -1, -1);

        // R6: in-order stall on a taken port
        q.push_back(mk(9, 20)); q.push_back(mk(8, 21)); q.push_back(mk(1, 22));
        run("R6", -1, -1);

        // R7: stop inside the head bundle
        q.push_back(mk(3, 23)); q.push_back(mk(2, 24)); q.push_back(mk(22, 25));
        run("R7", -1, -1);

        // R8: pairing allowed and refused
        q.push_back(mk(22, 26)); q.push_back(mk(12, 27));
        q.push_back(mk(23, 28)); q.push_back(mk(12, 29));
        q.push_back(mk(22, 30)); q.push_back(mk(2, 31));
        q.push_back(mk(16, 32)); q.push_back(mk(28, 33));
        q.push_back(mk(20, 34)); q.push_back(mk(29, 35));
        q.push_back(mk(12, 36)); q.push_back(mk(22, 37));
        run("R8", -1, -1);

        // R10: illegal head and illegal second bundle
        q.push_back(mk(30, 38)); q.push_back(mk(10, 39));
        q.push_back(mk(22, 40)); q.push_back(mk(14, 41)); q.push_back(mk(23, 42));
        run("R10", -1, -1);

        // R11: idle cycle in the middle of a bundle keeps progress
        q.push_back(mk(8, 43)); q.push_back(mk(12, 44));
        run("R11", 1, -1);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule